// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps the reservations made by load-linked requests for a small array of cache lines and decides whether a store-conditional write may go ahead. Each requester is identified by a CPU number and a thread number. Each line has a few reservation slots, so several contexts can hold reservations on the same line at once. A load-linked request adds the requester's context to the addressed line. A store-conditional succeeds when a reservation on that line matches both fields of the requester. Ordinary stores, store-conditionals and invalidations wipe all reservations on a line.

A cache controller presents one request per cycle on the request channel and any line invalidation on the invalidate channel. One cycle later the block returns a registered response: a valid flag, a write-proceed flag, and the store-conditional result bit. The response stage is a four-state machine. RSP_NONE is entered after an idle cycle. RSP_PASS is entered after a load, load-linked or store. RSP_SC_OK is entered after a store-conditional that matched. RSP_SC_FAIL is entered after a store-conditional that did not match. Every cycle the next state is chosen from the current request alone, so any state can move to any other. Data storage, tag lookup, coherence and replacement are handled elsewhere.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked (op code 2) on a line records the requester's CPU and thread numbers, and a later store-conditional (op code 4) from that same context on that line succeeds.
- R2: Repeated load-linked requests from one context give the same results as a single one. The following store-conditional succeeds, and a second store-conditional after it fails.
- R3: A store-conditional fails when no reservation on the line matches both fields. A match on the CPU number alone or on the thread number alone is not enough.
- R4: For a store-conditional, `rsp_sc_ok` is 1 on success and 0 on failure.
- R5: After any store-conditional, successful or failed, the line holds no reservation for any context.
- R6: An ordinary store (op code 3) always proceeds with `rsp_sc_ok` 0, and it clears every reservation on its line.
- R7: Asserting `inv_en` with `inv_line` clears every reservation on that line and leaves all other lines unchanged.
- R8: `rsp_proceed` is 0 only in the response to a failed store-conditional. Loads (op code 1), load-linked requests and stores respond with proceed 1 and `rsp_sc_ok` 0.
- R9: Each line has 4 slots. When a fifth load-linked arrives on a full line, it overwrites the oldest slot, chosen by a per-line round-robin pointer.
- R10: An invalidate and a request on the same line in the same cycle act as the request first and the invalidate second. A load-linked in that cycle leaves no reservation behind. A store-conditional in that cycle is judged on the reservations held before the cycle.
- R11: `rsp_valid` is 1 in the cycle after each request with op code 1 to 4. It is 0 after idle (op code 0) and after the unused codes 5 to 7, which are treated as idle.
- R12: Reset clears all reservations and all response outputs. Loads, idle cycles and requests to other lines leave a line's reservations unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_op | input | 3 | Request type: 0 idle, 1 load, 2 load-linked, 3 store, 4 store-conditional |
| req_line | input | 3 | Line addressed by the request |
| req_cpu | input | 2 | CPU number of the requester |
| req_thr | input | 2 | Thread number of the requester |
| inv_en | input | 1 | Invalidate strobe |
| inv_line | input | 3 | Line to invalidate |
| rsp_valid | output | 1 | Response present for the previous cycle's request |
| rsp_proceed | output | 1 | The write may proceed; low only for a failed store-conditional |
| rsp_sc_ok | output | 1 | Store-conditional result bit |

## Verification
The store-conditional decision is tested with several request patterns:
- A matching load-linked then store-conditional, which separates success from failure.
- Contexts that share only the CPU number or only the thread number, which catch a half-width compare.
- Two contexts reserving the same line, where one context's store-conditional must also wipe the other's reservation.
- Duplicate load-linked requests and a fifth load-linked on a full line, which check the slot count and the round-robin replacement.
- Stores, invalidates of the same line and of other lines, same-cycle invalidate with request, and a mid-run reset, which separate clears of one line from clears of the whole array and show the order in which a same-cycle request and invalidate take effect.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_LL    = 3'd2,
        OP_STORE = 3'd3,
        OP_SC    = 3'd4
    } op_t;

    typedef enum logic [1:0] {
        RSP_NONE    = 2'd0,
        RSP_PASS    = 2'd1,
        RSP_SC_OK   = 2'd2,
        RSP_SC_FAIL = 2'd3
    } rsp_state_t;

endpackage

// File: rtl/llsc_line.sv
module llsc_line
    import llsc_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int CPU_W = 2,
    parameter int THR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_sel,
    input  logic [2:0]       req_op,
    input  logic [CPU_W-1:0] req_cpu,
    input  logic [THR_W-1:0] req_thr,
    input  logic             inv_hit,
    output logic             match
);
    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [SLOTS-1:0] slot_vld;
    logic [CPU_W-1:0] slot_cpu [SLOTS];
    logic [THR_W-1:0] slot_thr [SLOTS];
    logic [PTR_W-1:0] wr_ptr;
    logic [SLOTS-1:0] slot_hit;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign slot_hit[s] = slot_vld[s] && (slot_cpu[s] == req_cpu)
                                         && (slot_thr[s] == req_thr);
    end

    assign match = |slot_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_vld <= '0;
            wr_ptr   <= '0;
        end else begin
            if (req_sel) begin
                unique case (op_t'(req_op))
                    OP_LL: begin
                        slot_vld[wr_ptr] <= 1'b1;
                        slot_cpu[wr_ptr] <= req_cpu;
                        slot_thr[wr_ptr] <= req_thr;
                        wr_ptr <= (wr_ptr == PTR_W'(SLOTS - 1)) ? '0 : wr_ptr + 1'b1;
                    end
                    OP_STORE, OP_SC: slot_vld <= '0;
                    default: ;
                endcase
            end
            if (inv_hit) begin
                slot_vld <= '0;
            end
        end
    end
endmodule

// File: rtl/llsc_resp.sv
module llsc_resp
    import llsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] req_op,
    input  logic       line_hit,
    output logic       rsp_valid,
    output logic       rsp_proceed,
    output logic       rsp_sc_ok
);
    rsp_state_t state_q, state_d;

    always_comb begin
        unique case (op_t'(req_op))
            OP_LOAD, OP_LL, OP_STORE: state_d = RSP_PASS;
            OP_SC:   state_d = line_hit ? RSP_SC_OK : RSP_SC_FAIL;
            default: state_d = RSP_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RSP_NONE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            RSP_NONE:    begin rsp_valid = 1'b0; rsp_proceed = 1'b0; rsp_sc_ok = 1'b0; end
            RSP_PASS:    begin rsp_valid = 1'b1; rsp_proceed = 1'b1; rsp_sc_ok = 1'b0; end
            RSP_SC_OK:   begin rsp_valid = 1'b1; rsp_proceed = 1'b1; rsp_sc_ok = 1'b1; end
            RSP_SC_FAIL: begin rsp_valid = 1'b1; rsp_proceed = 1'b0; rsp_sc_ok = 1'b0; end
            default:     begin rsp_valid = 1'b0; rsp_proceed = 1'b0; rsp_sc_ok = 1'b0; end
        endcase
    end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int LINE_W    = $clog2(NUM_LINES),
    parameter int SLOTS     = 4,
    parameter int CPU_W     = 2,
    parameter int THR_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        req_op,
    input  logic [LINE_W-1:0] req_line,
    input  logic [CPU_W-1:0]  req_cpu,
    input  logic [THR_W-1:0]  req_thr,
    input  logic              inv_en,
    input  logic [LINE_W-1:0] inv_line,
    output logic              rsp_valid,
    output logic              rsp_proceed,
    output logic              rsp_sc_ok
);
    logic [NUM_LINES-1:0] line_match;
    logic                 line_hit;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        llsc_line #(
            .SLOTS (SLOTS),
            .CPU_W (CPU_W),
            .THR_W (THR_W)
        ) i_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_sel (req_line == LINE_W'(g)),
            .req_op  (req_op),
            .req_cpu (req_cpu),
            .req_thr (req_thr),
            .inv_hit (inv_en && (inv_line == LINE_W'(g))),
            .match   (line_match[g])
        );
    end

    assign line_hit = line_match[req_line];

    llsc_resp i_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_op      (req_op),
        .line_hit    (line_hit),
        .rsp_valid   (rsp_valid),
        .rsp_proceed (rsp_proceed),
        .rsp_sc_ok   (rsp_sc_ok)
    );
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk
    import llsc_pkg::*;
#(
    parameter int LINE_W = 3,
    parameter int CPU_W  = 2,
    parameter int THR_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        req_op,
    input logic [LINE_W-1:0] req_line,
    input logic [CPU_W-1:0]  req_cpu,
    input logic [THR_W-1:0]  req_thr,
    input logic              inv_en,
    input logic [LINE_W-1:0] inv_line,
    input logic              rsp_valid,
    input logic              rsp_proceed,
    input logic              rsp_sc_ok
);
    logic op_real;
    assign op_real = (req_op >= 3'd1) && (req_op <= 3'd4);

    // R11
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_real |=> rsp_valid);

    // R11
    no_resp_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_real |=> !rsp_valid);

    // R8
    deny_only_failed_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op != OP_SC) |=> rsp_proceed || !rsp_valid);

    // R4
    sc_ok_implies_proceed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_sc_ok |-> rsp_valid && rsp_proceed);

    // R6
    store_proceeds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == OP_STORE) |=> rsp_proceed && !rsp_sc_ok);

    // R1
    ll_then_sc_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_op == OP_LL) && !(inv_en && (inv_line == req_line)))
        ##1 ((req_op == OP_SC) && $stable(req_line) && $stable(req_cpu) && $stable(req_thr))
        |=> rsp_sc_ok);

    // R5
    sc_then_sc_loses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == OP_SC) ##1 ((req_op == OP_SC) && $stable(req_line))
        |=> !rsp_sc_ok);

    // R7
    inv_then_sc_loses_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en ##1 ((req_op == OP_SC) && (req_line == $past(inv_line)))
        |=> !rsp_sc_ok);
endmodule

bind llsc_monitor llsc_monitor_chk #(
    .LINE_W (LINE_W),
    .CPU_W  (CPU_W),
    .THR_W  (THR_W)
) i_chk (.*);

// File: tb/test_llsc_monitor.sv
module test_llsc_monitor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req_op = '0;
    logic [2:0] req_line = '0;
    logic [1:0] req_cpu = '0;
    logic [1:0] req_thr = '0;
    logic       inv_en = 1'b0;
    logic [2:0] inv_line = '0;
    logic       rsp_valid, rsp_proceed, rsp_sc_ok;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    llsc_monitor i_llsc_monitor (.*);

    // row: {req tag, op, line, cpu, thr, exp valid, exp proceed, exp sc}
    // ops: 0 idle, 1 load, 2 LL, 3 store, 4 SC
    localparam int NV = 38;
    localparam logic [16:0] VEC [NV] = '{
        {4'd1,  3'd2, 3'd1, 2'd1, 2'd2, 3'b110}, // R1 reserve
        {4'd1,  3'd4, 3'd1, 2'd1, 2'd2, 3'b111}, // R1 R4 success
        {4'd5,  3'd4, 3'd1, 2'd1, 2'd2, 3'b100}, // R5 cleared after SC
        {4'd2,  3'd2, 3'd2, 2'd0, 2'd0, 3'b110}, // R2 first LL
        {4'd2,  3'd2, 3'd2, 2'd0, 2'd0, 3'b110}, // R2 duplicate
        {4'd2,  3'd4, 3'd2, 2'd0, 2'd0, 3'b111}, // R2 success
        {4'd2,  3'd4, 3'd2, 2'd0, 2'd0, 3'b100}, // R2 duplicate gone too
        {4'd3,  3'd2, 3'd3, 2'd1, 2'd1, 3'b110},
        {4'd3,  3'd4, 3'd3, 2'd1, 2'd0, 3'b100}, // R3 thread differs
        {4'd3,  3'd2, 3'd3, 2'd1, 2'd1, 3'b110},
        {4'd3,  3'd4, 3'd3, 2'd2, 2'd1, 3'b100}, // R3 cpu differs
        {4'd5,  3'd2, 3'd4, 2'd2, 2'd3, 3'b110},
        {4'd5,  3'd2, 3'd4, 2'd3, 2'd3, 3'b110},
        {4'd5,  3'd4, 3'd4, 2'd3, 2'd3, 3'b111},
        {4'd5,  3'd4, 3'd4, 2'd2, 2'd3, 3'b100}, // R5 other context wiped
        {4'd6,  3'd2, 3'd5, 2'd0, 2'd1, 3'b110},
        {4'd6,  3'd3, 3'd5, 2'd3, 2'd3, 3'b110}, // R6 store proceeds
        {4'd6,  3'd4, 3'd5, 2'd0, 2'd1, 3'b100}, // R6 store cleared line
        {4'd12, 3'd2, 3'd6, 2'd1, 2'd1, 3'b110},
        {4'd8,  3'd1, 3'd6, 2'd2, 2'd2, 3'b110}, // R8 load proceeds
        {4'd11, 3'd0, 3'd6, 2'd1, 2'd1, 3'b000}, // R11 idle
        {4'd11, 3'd7, 3'd6, 2'd1, 2'd1, 3'b000}, // R11 unused code
        {4'd12, 3'd4, 3'd6, 2'd1, 2'd1, 3'b111}, // R12 load/idle kept it
        {4'd12, 3'd2, 3'd7, 2'd3, 2'd0, 3'b110},
        {4'd12, 3'd2, 3'd0, 2'd3, 2'd0, 3'b110},
        {4'd12, 3'd4, 3'd0, 2'd3, 2'd0, 3'b111},
        {4'd12, 3'd4, 3'd7, 2'd3, 2'd0, 3'b111}, // R12 other line untouched
        {4'd9,  3'd2, 3'd3, 2'd0, 2'd0, 3'b110},
        {4'd9,  3'd2, 3'd3, 2'd0, 2'd1, 3'b110},
        {4'd9,  3'd2, 3'd3, 2'd0, 2'd2, 3'b110},
        {4'd9,  3'd2, 3'd3, 2'd0, 2'd3, 3'b110},
        {4'd9,  3'd2, 3'd3, 2'd1, 2'd0, 3'b110}, // R9 fifth overwrites oldest
        {4'd9,  3'd4, 3'd3, 2'd0, 2'd0, 3'b100}, // R9 oldest lost
        {4'd9,  3'd2, 3'd3, 2'd2, 2'd0, 3'b110},
        {4'd9,  3'd2, 3'd3, 2'd2, 2'd1, 3'b110},
        {4'd9,  3'd2, 3'd3, 2'd2, 2'd2, 3'b110},
        {4'd9,  3'd2, 3'd3, 2'd2, 2'd3, 3'b110},
        {4'd9,  3'd4, 3'd3, 2'd2, 2'd3, 3'b111}  // R9 four slots held
    };

    task automatic check(input int rq, input logic [2:0] exp);
        total++;
        if ({rsp_valid, rsp_proceed, rsp_sc_ok} !== exp) begin
            bad++;
            $display("FAIL R%0d: valid/proceed/sc actual=%b expected=%b",
                     rq, {rsp_valid, rsp_proceed, rsp_sc_ok}, exp);
        end
    endtask

    // drive on a falling edge, sample on the next falling edge
    task automatic step(input logic [2:0] op, input logic [2:0] ln,
                        input logic [1:0] cpu, input logic [1:0] thr,
                        input logic ie, input logic [2:0] il,
                        input int rq, input logic [2:0] exp);
        req_op = op; req_line = ln; req_cpu = cpu; req_thr = thr;
        inv_en = ie; inv_line = il;
        @(negedge clk);
        check(rq, exp);
    endtask

    initial begin : watchdog
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(12, 3'b000);                 // R12 reset state
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][12:10], VEC[i][9:7], VEC[i][6:5], VEC[i][4:3],
                 1'b0, 3'd0, int'(VEC[i][16:13]), VEC[i][2:0]);
        end

        // R7 invalidate clears the line
        step(3'd2, 3'd2, 2'd1, 2'd1, 1'b0, 3'd0, 7, 3'b110);
        step(3'd0, 3'd0, 2'd0, 2'd0, 1'b1, 3'd2, 7, 3'b000);
        step(3'd4, 3'd2, 2'd1, 2'd1, 1'b0, 3'd0, 7, 3'b100);
        // R7 invalidate of another line has no effect
        step(3'd2, 3'd6, 2'd0, 2'd0, 1'b0, 3'd0, 7, 3'b110);
        step(3'd0, 3'd0, 2'd0, 2'd0, 1'b1, 3'd1, 7, 3'b000);
        step(3'd4, 3'd6, 2'd0, 2'd0, 1'b0, 3'd0, 7, 3'b111);
        // R10 LL with same-cycle invalidate leaves nothing
        step(3'd2, 3'd4, 2'd0, 2'd0, 1'b1, 3'd4, 10, 3'b110);
        step(3'd4, 3'd4, 2'd0, 2'd0, 1'b0, 3'd0, 10, 3'b100);
        // R10 SC with same-cycle invalidate sees earlier reservation
        step(3'd2, 3'd5, 2'd2, 2'd2, 1'b0, 3'd0, 10, 3'b110);
        step(3'd4, 3'd5, 2'd2, 2'd2, 1'b1, 3'd5, 10, 3'b111);

        // R12 reset mid-run wipes reservations and outputs
        step(3'd2, 3'd0, 2'd1, 2'd1, 1'b0, 3'd0, 12, 3'b110);
        req_op = 3'd2;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(12, 3'b000);
        rst_n = 1'b1;
        step(3'd4, 3'd0, 2'd1, 2'd1, 1'b0, 3'd0, 12, 3'b100);
        step(3'd0, 3'd0, 2'd0, 2'd0, 1'b0, 3'd0, 11, 3'b000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule